// File: doc/BRIEF.md
# Preloadable 8-bit Timer/Event Counter

This block is a small up-counter that a processor programs through a register read/write port. Software places a start value in a preload register and picks one of three counting modes. In event mode the counter advances on edges of an external pin. In timer mode it advances on a programmable division of the system clock enable. In pulse-width mode it counts the divided clock for as long as the pin holds a chosen level. When the count passes its top value it reloads from the preload register, raises a sticky interrupt flag and toggles a divided-frequency output.

The pin is synchronised before any edge is detected. All counting uses single-cycle enables inside the one clock domain. A pulse-width measurement runs once only. When it ends, the counter stops itself and keeps the measured value until software arms it again. Reading the live count freezes the counter for that cycle, so the value read is coherent.

Top module: `evt_timer8`

## Requirements
- R1: After reset the counter, preload register, control register (address 1) and status register (address 2) all read 0, and irq_o and pfd_o are 0.
- R2: A write to the data address (0) while the run bit (control bit 4) is 0 loads both the preload register and the counter. A read of address 0 returns the counter in reg_rdata_o on the cycle after reg_rd_i.
- R3: A write to address 0 while the run bit is 1 changes only the preload register. The counter keeps counting and takes the new value at its next overflow.
- R4: In timer mode (control bits 6:5 = 2'b10), the counter advances once every 2^N system ticks, where N is control bits 2:0.
- R5: When the counter is at 0xFF and advances, it reloads from the preload register and sets the status flag (status bit 0). The flag stays set until software writes status with bit 0 = 0.
- R6: irq_o is 1 exactly when the status flag and the interrupt enable (status bit 1) are both 1.
- R7: In event mode (bits 6:5 = 2'b01), the counter advances once per edge of the synchronised pin. It counts rising edges when the edge bit (control bit 3) is 1 and falling edges when it is 0.
- R8: In pulse-width mode (bits 6:5 = 2'b11), with the edge bit at 1 a rising pin edge starts the count; with the edge bit at 0 a falling edge starts it. The counter advances each divided tick while the pin holds the level it moved to. When the pin returns, the run bit clears by itself and the count is kept. Later pulses change nothing until software sets the run bit again.
- R9: The counter does not advance in a cycle in which address 0 is read.
- R10: Each overflow toggles an internal divided-frequency bit. pfd_o shows that bit only while the output enable (control bit 7) is 1, and is 0 otherwise.
- R11: With mode bits 2'b00, the counter never advances, even when the run bit is 1.
- R12: In timer and event modes, the run bit changes only when software writes the control register; overflows leave it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_tick_i | input | 1 | System clock enable that feeds the prescaler |
| reg_addr_i | input | 2 | Register address: 0 data, 1 control, 2 status |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | CNT_W | Write data |
| reg_rdata_o | output | CNT_W | Read data, registered one cycle after the read strobe |
| ext_pin_i | input | 1 | External event / pulse input, asynchronous |
| irq_o | output | 1 | Interrupt request (flag AND enable) |
| pfd_o | output | 1 | Divided-frequency output, gated by its enable |

## Verification
The bench writes a new preload value while the counter runs. A design that also loads the live counter would return a different count after the reload than one that waits for the overflow. Pulse-width runs in both polarities check three things: the start cycle is counted, the count stops when the pin returns, and a second pulse after the automatic stop leaves the result alone. A design that re-arms itself would add the second pulse to the stored count. A burst of data reads inside a timed window must remove exactly one count per read, and a prescaled window must give an exact count, which exposes an off-by-one in the divider mask. Event counting with each edge setting catches a design that counts both edges.

// File: rtl/evt_timer8_pkg.sv
package evt_timer8_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } tmode_e;

  localparam int SEL_W  = 3;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  // control byte: [7] output enable, [6:5] mode, [4] run, [3] edge, [2:0] prescale
  typedef struct packed {
    logic             oe;
    tmode_e           mode;
    logic             run;
    logic             edge_hi;
    logic [SEL_W-1:0] psel;
  } ctrl_t;

endpackage

// File: rtl/evt_timer8_prescaler.sv
module evt_timer8_prescaler
  import evt_timer8_pkg::*;
#(
  parameter int PS_SEL_W = SEL_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sys_tick_i,
  input  logic [PS_SEL_W-1:0] sel_i,
  output logic                tick_o
);
  localparam int DIV_W = (1 << PS_SEL_W) - 1;
  localparam logic [DIV_W-1:0] DIV_ONE  = 1;
  localparam logic [DIV_W:0]   MASK_ONE = 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   span;
  logic [DIV_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst)             div_q <= '0;
    else if (sys_tick_i) div_q <= div_q + DIV_ONE;
  end

  always_comb begin
    span   = (MASK_ONE << sel_i) - MASK_ONE;
    mask   = span[DIV_W-1:0];
    tick_o = sys_tick_i & (&(div_q | ~mask));
  end

  // R4: a divided tick is never followed at once by another unless division is 1
  presc_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_o && sel_i != '0) |=> (!tick_o || sel_i == '0));

endmodule

// File: rtl/evt_timer8_pin_sync.sv
module evt_timer8_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;

  // R7: one pin transition yields a single-cycle edge pulse
  edge_single_chk: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);

endmodule

// File: rtl/evt_timer8_core.sv
module evt_timer8_core
  import evt_timer8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  tmode_e           mode_i,
  input  logic             edge_hi_i,
  input  logic             ptick_i,
  input  logic             level_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             hold_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] preload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             pw_done_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = 1;

  logic [CNT_W-1:0] cnt_q;
  logic             meas_q;
  logic             act_lvl, start_edge, end_edge;
  logic             pw_on, pw_start, pw_end;
  logic             evt, inc;

  always_comb begin
    act_lvl    = edge_hi_i ? level_i : ~level_i;
    start_edge = edge_hi_i ? rise_i : fall_i;
    end_edge   = edge_hi_i ? fall_i : rise_i;
    pw_on      = run_i && (mode_i == MODE_PULSE);
    pw_start   = pw_on && !meas_q && start_edge;
    pw_end     = pw_on && meas_q && end_edge;
    unique case (mode_i)
      MODE_EVENT: evt = start_edge;
      MODE_TIMER: evt = ptick_i;
      MODE_PULSE: evt = ptick_i && act_lvl && (meas_q || pw_start);
      default:    evt = 1'b0;
    endcase
    inc   = run_i && !hold_i && evt;
    ovf_o = inc && (cnt_q == CNT_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      meas_q <= 1'b0;
    end else begin
      if (load_i)     cnt_q <= load_val_i;
      else if (ovf_o) cnt_q <= preload_i;
      else if (inc)   cnt_q <= cnt_q + CNT_ONE;

      if (!pw_on)        meas_q <= 1'b0;
      else if (pw_start) meas_q <= 1'b1;
      else if (pw_end)   meas_q <= 1'b0;
    end
  end

  assign cnt_o     = cnt_q;
  assign pw_done_o = pw_end;

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> cnt_q == $past(preload_i));

  // R9
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_i && !load_i) |=> cnt_q == $past(cnt_q));

  // R11
  idle_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_IDLE && !load_i) |=> cnt_q == $past(cnt_q));

endmodule

// File: rtl/evt_timer8.sv
module evt_timer8
  import evt_timer8_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sys_tick_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  input  logic              ext_pin_i,
  output logic              irq_o,
  output logic              pfd_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] preload_q;
  logic             flag_q, ien_q, pfd_q;
  logic             data_wr, ctrl_wr, stat_wr, data_rd;
  logic             ptick, level, rise, fall;
  logic [CNT_W-1:0] cnt;
  logic             ovf, pw_done;
  logic [CNT_W-1:0] rd_mux;

  assign data_wr = reg_wr_i && (reg_addr_i == ADDR_DATA);
  assign ctrl_wr = reg_wr_i && (reg_addr_i == ADDR_CTRL);
  assign stat_wr = reg_wr_i && (reg_addr_i == ADDR_STAT);
  assign data_rd = reg_rd_i && (reg_addr_i == ADDR_DATA);

  evt_timer8_prescaler #(.PS_SEL_W(SEL_W)) u_presc (
    .clk(clk), .rst(rst), .sys_tick_i(sys_tick_i),
    .sel_i(ctrl_q.psel), .tick_o(ptick)
  );

  evt_timer8_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(ext_pin_i),
    .level_o(level), .rise_o(rise), .fall_o(fall)
  );

  evt_timer8_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst),
    .run_i(ctrl_q.run), .mode_i(ctrl_q.mode), .edge_hi_i(ctrl_q.edge_hi),
    .ptick_i(ptick), .level_i(level), .rise_i(rise), .fall_i(fall),
    .hold_i(data_rd), .load_i(data_wr && !ctrl_q.run),
    .load_val_i(reg_wdata_i), .preload_i(preload_q),
    .cnt_o(cnt), .ovf_o(ovf), .pw_done_o(pw_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      preload_q <= '0;
      flag_q    <= 1'b0;
      ien_q     <= 1'b0;
      pfd_q     <= 1'b0;
    end else begin
      if (data_wr) preload_q <= reg_wdata_i;

      if (ctrl_wr)      ctrl_q     <= ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
      else if (pw_done) ctrl_q.run <= 1'b0;

      if (ovf)                            flag_q <= 1'b1;
      else if (stat_wr && !reg_wdata_i[0]) flag_q <= 1'b0;
      if (stat_wr) ien_q <= reg_wdata_i[1];

      if (ovf) pfd_q <= ~pfd_q;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr_i)
      ADDR_DATA: rd_mux = cnt;
      ADDR_CTRL: rd_mux[CTRL_W-1:0] = ctrl_q;
      ADDR_STAT: rd_mux[1:0] = {ien_q, flag_q};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           reg_rdata_o <= '0;
    else if (reg_rd_i) reg_rdata_o <= rd_mux;
  end

  assign irq_o = flag_q & ien_q;
  assign pfd_o = pfd_q & ctrl_q.oe;

  // R8
  pw_autoclear_chk: assert property (@(posedge clk) disable iff (rst)
    (pw_done && !ctrl_wr) |=> !ctrl_q.run);

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(stat_wr && !reg_wdata_i[0])) |=> flag_q);

  // R2
  stopped_load_chk: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !ctrl_q.run) |=> cnt == $past(reg_wdata_i));

  // R12
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.run && ctrl_q.mode != MODE_PULSE && !ctrl_wr) |=> ctrl_q.run);

endmodule

// File: tb/evt_timer8_tb.sv
module evt_timer8_tb;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sys_tick = 1'b1;
  logic [1:0] addr = '0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pin = 1'b0;
  logic       irq, pfd;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  evt_timer8 u_dut (
    .clk(clk), .rst(rst), .sys_tick_i(sys_tick),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ext_pin_i(pin), .irq_o(irq), .pfd_o(pfd)
  );

  localparam logic [1:0] A_DATA = 2'd0, A_CTRL = 2'd1, A_STAT = 2'd2;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic reset_dut();
    @(negedge clk); rst = 1'b1; pin = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input int hi, input int lo);
    pin = 1'b1;
    repeat (hi) @(negedge clk);
    pin = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    reset_dut();
    rreg(A_DATA, v); chk("R1 counter", v, 8'h00);
    rreg(A_CTRL, v); chk("R1 control", v, 8'h00);
    rreg(A_STAT, v); chk("R1 status", v, 8'h00);
    chk("R1 irq_o", {7'd0, irq}, 8'h00);
    chk("R1 pfd_o", {7'd0, pfd}, 8'h00);
  endtask

  task automatic t_stopped_load();
    logic [7:0] v;
    reset_dut();
    wreg(A_DATA, 8'h5A);
    rreg(A_DATA, v); chk("R2 stopped write loads counter", v, 8'h5A);
  endtask

  task automatic t_running_write();
    logic [7:0] v;
    reset_dut();
    wreg(A_DATA, 8'hF0);
    wreg(A_CTRL, 8'h50);        // timer, run, N=0
    wreg(A_DATA, 8'h80);        // preload only
    repeat (17) @(negedge clk);
    wreg(A_CTRL, 8'h00);        // 19 counts total
    rreg(A_DATA, v); chk("R3 running write waits for overflow", v, 8'h83);
  endtask

  task automatic t_timer_rate();
    logic [7:0] v;
    reset_dut();
    wreg(A_DATA, 8'h00);
    wreg(A_CTRL, 8'h50);
    repeat (11) @(negedge clk);
    wreg(A_CTRL, 8'h00);
    rreg(A_DATA, v); chk("R4 divide by 1", v, 8'h0C);
    wreg(A_DATA, 8'h00);
    wreg(A_CTRL, 8'h52);        // N=2
    repeat (39) @(negedge clk);
    wreg(A_CTRL, 8'h00);
    rreg(A_DATA, v); chk("R4 divide by 4", v, 8'h0A);
  endtask

  task automatic t_overflow_flag();
    logic [7:0] v;
    reset_dut();
    wreg(A_DATA, 8'hFD);
    wreg(A_CTRL, 8'h50);
    repeat (4) @(negedge clk);
    wreg(A_CTRL, 8'h00);        // 5 counts: FE FF FD FE FF
    rreg(A_DATA, v); chk("R5 reload after overflow", v, 8'hFF);
    repeat (10) @(negedge clk);
    rreg(A_STAT, v); chk("R5 flag sticky", v, 8'h01);
    chk("R6 irq masked", {7'd0, irq}, 8'h00);
    wreg(A_STAT, 8'h03);
    chk("R6 irq enabled", {7'd0, irq}, 8'h01);
    wreg(A_STAT, 8'h02);
    rreg(A_STAT, v); chk("R5 flag cleared by write 0", v, 8'h02);
    chk("R6 irq after clear", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_event_edges();
    logic [7:0] v;
    reset_dut();
    wreg(A_CTRL, 8'h38);        // event, run, rising
    repeat (3) pulse(4, 4);
    repeat (4) @(negedge clk);
    wreg(A_CTRL, 8'h00);
    rreg(A_DATA, v); chk("R7 rising edges", v, 8'h03);
    wreg(A_DATA, 8'h00);
    wreg(A_CTRL, 8'h30);        // event, run, falling
    repeat (2) pulse(3, 5);
    repeat (4) @(negedge clk);
    wreg(A_CTRL, 8'h00);
    rreg(A_DATA, v); chk("R7 falling edges", v, 8'h02);
  endtask

  task automatic t_pulse_width();
    logic [7:0] v;
    reset_dut();
    wreg(A_CTRL, 8'h78);        // pulse, run, high level
    repeat (3) @(negedge clk);
    pulse(10, 6);
    rreg(A_CTRL, v); chk("R8 run auto-cleared (high)", v, 8'h68);
    rreg(A_DATA, v); chk("R8 high width", v, 8'h0A);
    pulse(5, 6);
    rreg(A_DATA, v); chk("R8 later pulse ignored", v, 8'h0A);
    wreg(A_DATA, 8'h00);
    wreg(A_CTRL, 8'h70);        // pulse, run, low level
    pin = 1'b1; repeat (5) @(negedge clk);
    pin = 1'b0; repeat (7) @(negedge clk);
    pin = 1'b1; repeat (6) @(negedge clk);
    pin = 1'b0; repeat (4) @(negedge clk);
    rreg(A_DATA, v); chk("R8 low width", v, 8'h07);
    rreg(A_CTRL, v); chk("R8 run auto-cleared (low)", v, 8'h60);
  endtask

  task automatic t_read_hold();
    logic [7:0] v;
    reset_dut();
    wreg(A_DATA, 8'h00);
    wreg(A_CTRL, 8'h50);
    repeat (10) @(negedge clk);
    for (int i = 0; i < 5; i++) rreg(A_DATA, v);
    repeat (10) @(negedge clk);
    wreg(A_CTRL, 8'h00);        // 26 edges, 5 held
    rreg(A_DATA, v); chk("R9 reads hold count", v, 8'h15);
  endtask

  task automatic t_pfd_run();
    logic [7:0] v;
    reset_dut();
    wreg(A_DATA, 8'hFF);
    wreg(A_CTRL, 8'h80);
    chk("R10 pfd idle", {7'd0, pfd}, 8'h00);
    wreg(A_CTRL, 8'hD0);
    wreg(A_CTRL, 8'h80);        // one overflow
    chk("R10 pfd toggled", {7'd0, pfd}, 8'h01);
    wreg(A_CTRL, 8'h00);
    chk("R10 pfd gated off", {7'd0, pfd}, 8'h00);
    wreg(A_CTRL, 8'h80);
    chk("R10 pfd gated on", {7'd0, pfd}, 8'h01);
    wreg(A_CTRL, 8'hD0);
    repeat (3) @(negedge clk);
    rreg(A_CTRL, v); chk("R12 run kept through overflows", v, 8'hD0);
    wreg(A_CTRL, 8'h80);        // five more overflows
    chk("R10 pfd after odd overflows", {7'd0, pfd}, 8'h00);
  endtask

  task automatic t_idle();
    logic [7:0] v;
    reset_dut();
    wreg(A_DATA, 8'h05);
    wreg(A_CTRL, 8'h18);        // mode idle, run set
    repeat (3) pulse(3, 3);
    repeat (10) @(negedge clk);
    wreg(A_CTRL, 8'h00);
    rreg(A_DATA, v); chk("R11 idle mode holds", v, 8'h05);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_stopped_load();
    t_running_write();
    t_timer_rate();
    t_overflow_flag();
    t_event_edges();
    t_pulse_width();
    t_read_hold();
    t_pfd_run();
    t_idle();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule